// File: doc/BRIEF.md
# Converter Fault Supervisor with Timed Auto-Restart

This block decides, cycle by cycle, whether a switching power converter may switch. It watches four fault sources. The first is overcurrent that ends the on-time, counted over switching cycles by an up/down counter. The second is an external disable comparator, debounced in milliseconds. The third is a supply-clamp-current flag, debounced in switching cycles. The fourth is an over-temperature flag.

When any of these trips, switching is blanked for a fixed restart period. It then comes back through a stepped soft-start of the current-limit setpoint. A thermal trip is handled differently: after its blanking period, a short probe of a few switching cycles runs before the block decides between another blank and a normal restart.

Timing comes from two strobes supplied by the surrounding logic. One marks the start of each switching cycle and the other is a one-millisecond tick. All delays and debounce windows are parameters, so the same block serves different cycle rates.

Top module: `fault_restart_seq`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears every counter. After reset release, sw_en is 1 and ss_level is 0, so a soft-start begins.
- R2: While running, ss_level rises by one on each ms_tick until it reaches 7, then holds at 7. The current-limit setpoint is (ss_level+1)/8 of full. ss_level is 0 while switching is blanked or probing, and switching always resumes at level 0.
- R3: The overload count rises by one on each cyc_start with ocp_end high and falls by one, never below zero, on each cyc_start with ocp_end low. When it reaches OVL_LIMIT, the block trips and sw_en is 0 from the next clock.
- R4: After an overload trip, sw_en stays 0 for RESTART_MS ms_tick strobes, counted from the tick after the trip, then returns to 1 at the edge after the last of them. Removing the fault during this period does not shorten it.
- R5: dis_hi sampled high on DIS_DEB_MS consecutive ms_tick strobes trips the block, with a restart period of DIS_RESTART_MS ticks. dis_hi going low at any clock clears the debounce count.
- R6: clamp_hi sampled high on CLAMP_CYC consecutive cyc_start strobes trips the block, with a restart period of RESTART_MS ticks. The check is ignored and its count held at zero while ss_level is below 7.
- R7: otp_hi high at any clock while running trips at once, with a RESTART_MS blank. The blank is followed by a probe in which sw_en is 1 for PROBE_CYC cyc_start strobes. If otp_hi is high at the last probe strobe, another RESTART_MS blank follows; otherwise running resumes with a soft-start.
- R8: When several sources trip at the same clock, the longest of their restart periods applies, and a probe follows if one of them was thermal.
- R9: All fault inputs are ignored while blanked, and all but otp_hi at the last strobe are ignored while probing. Debounce and overload counts restart from zero after every trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| ocp_end | input | 1 | The cycle just ended was terminated by the overcurrent comparator |
| dis_hi | input | 1 | Disable comparator output |
| clamp_hi | input | 1 | Supply clamp current above threshold |
| otp_hi | input | 1 | Over-temperature flag |
| ms_tick | input | 1 | One-clock strobe every millisecond |
| sw_en | output | 1 | Switching allowed |
| ss_level | output | 3 | Soft-start level, setpoint = (ss_level+1)/8 |

## Verification
The hard case is two fault paths tripping on the same clock with different restart periods. The bench brings this about by holding the disable input through two ticks and then raising the over-temperature flag exactly in the clock whose tick completes the disable debounce. The 500 ms-class and 1 s-class delays then compete, and a probe must also follow. A cycle-accurate behavioural model, compared on every clock, judges the result. Directed checks confirm that switching is still off after the shorter period has passed, and that the probe then starts at level 0.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_BLANK = 2'd1,
    PH_PROBE = 2'd2
  } phase_e;

  // Saturating up/down step of the overload count.
  function automatic int unsigned ovl_next(int unsigned cnt, bit up);
    if (up) return cnt + 1;
    if (cnt == 0) return 0;
    return cnt - 1;
  endfunction

  // Longest restart delay among the sources that tripped.
  function automatic int unsigned longest_delay(bit a, int unsigned a_len,
                                                bit b, int unsigned b_len);
    int unsigned r;
    r = 0;
    if (a && a_len > r) r = a_len;
    if (b && b_len > r) r = b_len;
    return r;
  endfunction

endpackage

// File: rtl/fsq_ovl_counter.sv
module fsq_ovl_counter #(
  parameter int unsigned LIMIT = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stb,
  input  logic ocp,
  output logic trip
);
  import fsq_pkg::*;

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign trip = en && stb && ocp && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || trip) begin
      cnt <= '0;
    end else if (stb) begin
      cnt <= CW'(ovl_next(int'(cnt), ocp));
    end
  end

endmodule

// File: rtl/fsq_debounce.sv
module fsq_debounce #(
  parameter int unsigned LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  input  logic stb,
  output logic trip
);

  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign trip = en && lvl && stb && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || !lvl || trip) begin
      cnt <= '0;
    end else if (stb) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fsq_softstart.sv
module fsq_softstart #(
  parameter int unsigned SS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            run,
  input  logic            tick,
  output logic [SS_W-1:0] level,
  output logic            at_full
);

  localparam logic [SS_W-1:0] SS_MAX = {SS_W{1'b1}};

  assign at_full = (level == SS_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
    end else if (restart) begin
      level <= '0;
    end else if (run && tick && !at_full) begin
      level <= level + 1'b1;
    end
  end

endmodule

// File: rtl/fault_restart_seq.sv
module fault_restart_seq #(
  parameter int unsigned OVL_LIMIT      = 3000,
  parameter int unsigned CLAMP_CYC      = 30,
  parameter int unsigned DIS_DEB_MS     = 1,
  parameter int unsigned DIS_RESTART_MS = 500,
  parameter int unsigned RESTART_MS     = 1000,
  parameter int unsigned PROBE_CYC      = 3,
  parameter int unsigned SS_W           = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic            ocp_end,
  input  logic            dis_hi,
  input  logic            clamp_hi,
  input  logic            otp_hi,
  input  logic            ms_tick,
  output logic            sw_en,
  output logic [SS_W-1:0] ss_level
);
  import fsq_pkg::*;

  localparam int unsigned MAX_DLY = (RESTART_MS > DIS_RESTART_MS) ? RESTART_MS : DIS_RESTART_MS;
  localparam int unsigned DLY_W   = $clog2(MAX_DLY + 1);
  localparam int unsigned PRB_W   = $clog2(PROBE_CYC + 1);

  phase_e             phase;
  logic [DLY_W-1:0]   blank_cnt;
  logic [DLY_W-1:0]   blank_len;
  logic [PRB_W-1:0]   probe_cnt;
  logic               therm_pend;

  // Named internal events
  logic run;
  logic ss_full;
  logic ovl_trip;
  logic dis_trip;
  logic clamp_trip;
  logic otp_trip;
  logic any_trip;
  logic blank_done;
  logic probe_done;
  logic probe_fail;
  logic [DLY_W-1:0] trip_len;

  assign run = (phase == PH_RUN);

  fsq_ovl_counter #(.LIMIT(OVL_LIMIT)) u_ovl (
    .clk(clk), .rst_n(rst_n), .en(run), .stb(cyc_start), .ocp(ocp_end), .trip(ovl_trip)
  );

  fsq_debounce #(.LIMIT(DIS_DEB_MS)) u_dis (
    .clk(clk), .rst_n(rst_n), .en(run), .lvl(dis_hi), .stb(ms_tick), .trip(dis_trip)
  );

  fsq_debounce #(.LIMIT(CLAMP_CYC)) u_clamp (
    .clk(clk), .rst_n(rst_n), .en(run && ss_full), .lvl(clamp_hi), .stb(cyc_start),
    .trip(clamp_trip)
  );

  fsq_softstart #(.SS_W(SS_W)) u_ss (
    .clk(clk), .rst_n(rst_n), .restart(any_trip), .run(run), .tick(ms_tick),
    .level(ss_level), .at_full(ss_full)
  );

  assign otp_trip   = run && otp_hi;
  assign any_trip   = ovl_trip || dis_trip || clamp_trip || otp_trip;
  assign trip_len   = DLY_W'(longest_delay(ovl_trip || clamp_trip || otp_trip, RESTART_MS,
                                           dis_trip, DIS_RESTART_MS));
  assign blank_done = (phase == PH_BLANK) && ms_tick && (blank_cnt == blank_len - 1'b1);
  assign probe_done = (phase == PH_PROBE) && cyc_start && (probe_cnt == PRB_W'(PROBE_CYC - 1));
  assign probe_fail = probe_done && otp_hi;

  assign sw_en = (phase != PH_BLANK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_RUN;
      blank_cnt  <= '0;
      blank_len  <= '0;
      probe_cnt  <= '0;
      therm_pend <= 1'b0;
    end else begin
      case (phase)
        PH_RUN: begin
          if (any_trip) begin
            phase      <= PH_BLANK;
            blank_cnt  <= '0;
            blank_len  <= trip_len;
            therm_pend <= otp_trip;
          end
        end
        PH_BLANK: begin
          if (blank_done) begin
            blank_cnt <= '0;
            probe_cnt <= '0;
            phase     <= therm_pend ? PH_PROBE : PH_RUN;
          end else if (ms_tick) begin
            blank_cnt <= blank_cnt + 1'b1;
          end
        end
        PH_PROBE: begin
          if (probe_fail) begin
            phase     <= PH_BLANK;
            blank_cnt <= '0;
            blank_len <= DLY_W'(RESTART_MS);
          end else if (probe_done) begin
            phase      <= PH_RUN;
            therm_pend <= 1'b0;
          end else if (cyc_start) begin
            probe_cnt <= probe_cnt + 1'b1;
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
  parameter int unsigned SS_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ms_tick,
  input logic            sw_en,
  input logic [SS_W-1:0] ss_level,
  input logic            any_trip,
  input logic            clamp_trip,
  input logic            probe_done
);

  localparam logic [SS_W-1:0] SS_MAX = {SS_W{1'b1}};

  assert_trip_blanks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_trip |=> !sw_en);

  assert_resume_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(ms_tick));

  assert_resume_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> (ss_level == '0));

  assert_ss_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && $past(sw_en) && (ss_level != $past(ss_level)))
      |-> (ss_level == $past(ss_level) + 1'b1));

  assert_clamp_after_soft_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_trip |-> (ss_level == SS_MAX));

  assert_probe_switches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    probe_done |-> sw_en);

endmodule

bind fault_restart_seq fsq_checker #(.SS_W(SS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sw_en(sw_en), .ss_level(ss_level),
  .any_trip(any_trip), .clamp_trip(clamp_trip), .probe_done(probe_done)
);

// File: tb/fault_restart_seq_tb_top.sv
module fault_restart_seq_tb_top;

  localparam int OVL   = 12;
  localparam int CLC   = 4;
  localparam int DDEB  = 3;
  localparam int DRST  = 20;
  localparam int RST   = 40;
  localparam int PRB   = 3;
  localparam int TDIV  = 4;
  localparam int CDIV  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, ocp_end = 1'b0, dis_hi = 1'b0, clamp_hi = 1'b0, otp_hi = 1'b0;
  logic ms_tick = 1'b0;
  logic sw_en;
  logic [2:0] ss_level;

  always #4 clk = ~clk;

  fault_restart_seq #(
    .OVL_LIMIT(OVL), .CLAMP_CYC(CLC), .DIS_DEB_MS(DDEB), .DIS_RESTART_MS(DRST),
    .RESTART_MS(RST), .PROBE_CYC(PRB), .SS_W(3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .ocp_end(ocp_end), .dis_hi(dis_hi),
    .clamp_hi(clamp_hi), .otp_hi(otp_hi), .ms_tick(ms_tick), .sw_en(sw_en), .ss_level(ss_level)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // strobe generators
  int tc = 0, cc = 0;
  always @(negedge clk) begin
    tc = (tc + 1) % TDIV;
    cc = (cc + 1) % CDIV;
    ms_tick <= (tc == 0);
    cyc_start <= (cc == 0);
  end

  // behavioural reference: 0 running, 1 blanked, 2 probing
  int m_ph, m_ss, m_ovl, m_dis, m_cl, m_left, m_probe;
  bit m_th;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ss = 0; m_ovl = 0; m_dis = 0; m_cl = 0; m_left = 0; m_probe = 0; m_th = 0;
    end else if (m_ph == 0) begin
      bit tr; bit th; int len;
      tr = 0; th = 0; len = 0;
      if (cyc_start) begin
        if (ocp_end) m_ovl++; else if (m_ovl > 0) m_ovl--;
        if (m_ovl >= OVL) begin tr = 1; len = (len > RST) ? len : RST; end
      end
      if (dis_hi) begin
        if (ms_tick) m_dis++;
        if (m_dis >= DDEB) begin tr = 1; len = (len > DRST) ? len : DRST; end
      end else m_dis = 0;
      if (m_ss == 7 && clamp_hi) begin
        if (cyc_start) m_cl++;
        if (m_cl >= CLC) begin tr = 1; len = (len > RST) ? len : RST; end
      end else m_cl = 0;
      if (otp_hi) begin tr = 1; th = 1; len = (len > RST) ? len : RST; end
      if (tr) begin
        m_ph = 1; m_left = len; m_th = th; m_ss = 0; m_ovl = 0; m_dis = 0; m_cl = 0;
      end else if (ms_tick && m_ss < 7) m_ss++;
    end else if (m_ph == 1) begin
      if (ms_tick) begin
        m_left--;
        if (m_left == 0) begin m_ph = m_th ? 2 : 0; m_probe = 0; end
      end
    end else begin
      if (cyc_start) begin
        m_probe++;
        if (m_probe == PRB) begin
          if (otp_hi) begin m_ph = 1; m_left = RST; end
          else begin m_ph = 0; m_th = 0; end
        end
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  bit seen_edge = 0;
  always @(posedge clk) if (rst_n) seen_edge <= 1;
  always @(negedge clk) begin
    if (rst_n && seen_edge && !done) begin
      chk(sw_en == (m_ph != 1), {cur_req, " sw_en"}, sw_en, (m_ph != 1));
      chk(ss_level == 3'(m_ss), {cur_req, " ss_level"}, ss_level, m_ss);
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_ticks(int n);
    repeat (n) begin
      @(posedge clk);
      while (!ms_tick) @(posedge clk);
    end
  endtask

  task automatic wait_strobes(int n);
    repeat (n) begin
      @(posedge clk);
      while (!cyc_start) @(posedge clk);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic wait_full();
    settle();
    while (!(sw_en && ss_level == 3'd7)) settle();
  endtask

  task automatic wait_en();
    settle();
    while (!sw_en) settle();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    settle(); rst_n = 1'b1;
    settle();
    cur_req = "R1";
    chk(sw_en == 1'b1, "R1 reset sw_en", sw_en, 1);
    chk(ss_level == 3'd0, "R1 reset ss_level", ss_level, 0);

    cur_req = "R2";
    wait_full();
    wait_ticks(3); settle();
    chk(ss_level == 3'd7, "R2 holds at full", ss_level, 7);

    // R3: up/down overload counting, then trip
    cur_req = "R3";
    ocp_end = 1; wait_strobes(8); settle();
    ocp_end = 0; wait_strobes(10); settle();
    ocp_end = 1; wait_strobes(11); settle();
    chk(sw_en == 1'b1, "R3 decay prevents trip", sw_en, 1);
    wait_strobes(1); settle();
    chk(sw_en == 1'b0, "R3 trip at limit", sw_en, 0);
    ocp_end = 0;
    cur_req = "R4";
    wait_ticks(30); settle();
    chk(sw_en == 1'b0, "R4 full period despite cleared fault", sw_en, 0);
    wait_en();
    chk(ss_level == 3'd0, "R4 resume at level 0", ss_level, 0);

    // R5: disable debounce
    cur_req = "R5";
    wait_full();
    dis_hi = 1; wait_ticks(DDEB - 1); settle();
    dis_hi = 0; wait_ticks(2); settle();
    chk(sw_en == 1'b1, "R5 short pulse ignored", sw_en, 1);
    dis_hi = 1; wait_ticks(DDEB); settle();
    chk(sw_en == 1'b0, "R5 debounced trip", sw_en, 0);
    cur_req = "R9";
    wait_ticks(10); settle();
    clamp_hi = 1; ocp_end = 1;
    wait_ticks(5); settle();
    dis_hi = 0; clamp_hi = 0; ocp_end = 0;
    wait_ticks(DRST - 15); settle();
    chk(sw_en == 1'b1, "R5 R9 shorter restart, blank inputs ignored", sw_en, 1);

    // R6: clamp ignored during soft-start
    cur_req = "R6";
    clamp_hi = 1;
    wait_full();
    chk(sw_en == 1'b1, "R6 ignored during soft-start", sw_en, 1);
    wait_strobes(CLC - 1); settle();
    chk(sw_en == 1'b1, "R6 before window", sw_en, 1);
    wait_strobes(1); settle();
    chk(sw_en == 1'b0, "R6 clamp trip", sw_en, 0);
    clamp_hi = 0;
    wait_en();

    // R7: thermal blank, failed probe, good probe
    cur_req = "R7";
    wait_full();
    otp_hi = 1; settle();
    chk(sw_en == 1'b0, "R7 immediate thermal trip", sw_en, 0);
    wait_en();
    chk(ss_level == 3'd0, "R7 probe at level 0", ss_level, 0);
    wait_strobes(PRB); settle();
    chk(sw_en == 1'b0, "R7 failed probe blanks again", sw_en, 0);
    otp_hi = 0;
    wait_en();
    wait_strobes(PRB); settle();
    chk(sw_en == 1'b1, "R7 good probe resumes", sw_en, 1);
    wait_ticks(8); settle();
    chk(ss_level == 3'd7, "R7 soft-start after probe", ss_level, 7);

    // R8: disable and thermal in the same clock
    cur_req = "R8";
    wait_full();
    wait_ticks(1); settle();
    dis_hi = 1; wait_ticks(DDEB - 1); settle();
    while (!ms_tick) settle();
    otp_hi = 1;
    settle();
    chk(sw_en == 1'b0, "R8 joint trip", sw_en, 0);
    dis_hi = 0; otp_hi = 0;
    wait_ticks(DRST + 5); settle();
    chk(sw_en == 1'b0, "R8 longest delay applies", sw_en, 0);
    wait_en();
    chk(ss_level == 3'd0, "R8 probe follows", ss_level, 0);
    wait_strobes(PRB); wait_ticks(9); settle();
    chk(ss_level == 3'd7, "R8 restart after probe", ss_level, 7);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule